// File: doc/BRIEF.md
# SPI Master Phased Transaction Sequencer

This block runs one SPI master transaction built from a fixed chain of optional phases: an optional chip-select lead-in, then command, address, dummy, write-data and read-data, then an optional chip-select tail. Each phase is switched on by its own enable input and its length is programmed as the count minus one. The serial clock runs at the system clock rate: in every cycle where `sck_en` is high, one bit is placed on `mosi` and, in receiving phases, `miso` is captured at the next rising clock edge.

Transmit data is taken from a 16-word by 32-bit buffer, and received bits are written back into the same buffer. The buffer is loaded and read back through a simple word port while the sequencer is idle. A one-cycle `start` pulse launches a transaction. `busy` stays high until the transaction has finished, `done` pulses once at the end, and `phase` shows the step in progress. Configuration inputs must be held stable while `busy` is high.

Top module: `spi_phase_seq`

## Requirements
- R1: After reset, and whenever idle, `cs_n`=1, `sck_en`=0, `mosi`=0, `busy`=0 and `phase`=0.
- R2: `phase` codes are idle=0, lead-in=1, command=2, address=3, dummy=4, write=5, read=6, tail=7. Enabled phases run in increasing code order, each lasting its length field plus one cycles. Disabled phases are skipped.
- R3: The command phase sends bits `cmd_len` down to 0 of `cmd_val` on `mosi`, one bit per cycle, with `sck_en` high.
- R4: The address phase sends bits `addr_len` down to 0 of the 64-bit value {`addr_hi`,`addr_lo`}, one bit per cycle, with `sck_en` high.
- R5: The dummy phase lasts `dummy_len`+1 cycles with `mosi`=0. During it, `sck_en` is high unless `dummy_idle` is set, in which case `sck_en` stays 0.
- R6: The write phase sends `wr_len`+1 bits. Bit number i comes from buffer word i/32 (plus 8 when `wr_upper` is set), at bit position 31-(i mod 32), so that bit 31 of word 0 is sent first.
- R7: In half duplex, the read phase lasts `rd_len`+1 cycles with `sck_en` high and `mosi`=0. Received bit i is stored at the position given by the R6 mapping, using `rd_upper`.
- R8: When `full_duplex` is set, the read phase is skipped and `miso` is captured in every write-phase cycle. Received bit i is stored by the R6 mapping using `rd_upper`.
- R9: `wr_upper` and `rd_upper` each confine their own direction to buffer words 8 to 15.
- R10: With `setup_en`, a lead-in of `setup_len`+1 cycles comes first. With `hold_en`, a tail of `hold_len`+1 cycles comes last. Both have `cs_n`=0 and `sck_en`=0.
- R11: A `start` pulse while idle begins a transaction. `cs_n` is 0 exactly while `busy` is 1, and `done` is high for the first idle cycle after the transaction.
- R12: While busy, `start` and `buf_we` are ignored: the transaction neither restarts nor repeats, and the buffer word is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the serial bit rate |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle launch pulse |
| en_cmd | input | 1 | Include command phase |
| en_addr | input | 1 | Include address phase |
| en_dummy | input | 1 | Include dummy phase |
| en_wr | input | 1 | Include write phase |
| en_rd | input | 1 | Include read phase (half duplex) |
| full_duplex | input | 1 | Capture miso during write phase, skip read phase |
| dummy_idle | input | 1 | No clock pulses during dummy phase |
| setup_en | input | 1 | Enable chip-select lead-in |
| hold_en | input | 1 | Enable chip-select tail |
| wr_upper | input | 1 | Write phase uses buffer words 8..15 |
| rd_upper | input | 1 | Received data goes to words 8..15 |
| setup_len | input | 4 | Lead-in cycles minus one |
| hold_len | input | 4 | Tail cycles minus one |
| cmd_len | input | 4 | Command bits minus one |
| cmd_val | input | 16 | Command value |
| addr_len | input | 6 | Address bits minus one |
| addr_lo | input | 32 | Address bits 31..0 |
| addr_hi | input | 32 | Address bits 63..32 |
| dummy_len | input | 8 | Dummy cycles minus one |
| wr_len | input | 24 | Write bits minus one |
| rd_len | input | 24 | Read bits minus one |
| buf_we | input | 1 | Host buffer word write |
| buf_addr | input | 4 | Host buffer word index |
| buf_wdata | input | 32 | Host write data |
| buf_rdata | output | 32 | Buffer word at buf_addr |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | End-of-transaction pulse |
| phase | output | 3 | Current phase code |
| cs_n | output | 1 | Chip select, active low |
| sck_en | output | 1 | Serial clock pulse enable for this cycle |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench drives transactions that mix 12-bit commands, 24-bit and 40-bit addresses, gated and running dummy cycles, lead-in and tail phases, and both duplex modes. An address longer than 32 bits catches a design that never reaches `addr_hi`. An off-by-one in any length field shows up as a phase that runs one cycle too long or too short. A swapped bit or word order shows up as wrong `mosi` bits and wrong words read back from the buffer. In full duplex, a design that still runs a read phase produces extra cycles. The last transaction is pulsed with `start` and a buffer write mid-flight: a design that restarts stays busy, and one that accepts the write corrupts word 15.

// File: rtl/spi_phase_seq_pkg.sv
package spi_phase_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_LEAD  = 3'd1,
        PH_CMD   = 3'd2,
        PH_ADDR  = 3'd3,
        PH_DUMMY = 3'd4,
        PH_WR    = 3'd5,
        PH_RD    = 3'd6,
        PH_TAIL  = 3'd7
    } phase_e;

    typedef struct packed {
        logic lead;
        logic cmd;
        logic addr;
        logic dummy;
        logic wr;
        logic rd;
        logic fdx;
        logic tail;
    } phase_en_t;

    // First enabled phase whose code is above cur; idle when none is left.
    function automatic phase_e next_phase(phase_e cur, phase_en_t e);
        logic [7:0] on;
        phase_e     nx;
        on = {e.tail, e.rd & ~e.fdx, e.wr, e.dummy, e.addr, e.cmd, e.lead, 1'b0};
        nx = PH_IDLE;
        for (int p = 7; p >= 1; p--) begin
            if (p > int'(cur) && on[p]) nx = phase_e'(p[2:0]);
        end
        return nx;
    endfunction

    function automatic logic shifts_bits(phase_e p);
        return (p == PH_CMD) || (p == PH_ADDR) || (p == PH_WR) || (p == PH_RD);
    endfunction

endpackage

// File: rtl/spi_phase_seq_ctrl.sv
module spi_phase_seq_ctrl
    import spi_phase_seq_pkg::*;
#(
    parameter int LEN_W = 24
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  phase_en_t             ena,
    input  logic [7:0][LEN_W-1:0] lens,
    output phase_e                phase,
    output logic [LEN_W-1:0]      cnt,
    output logic                  done
);
    logic [LEN_W-1:0] cur_len;
    phase_e           nx;

    assign cur_len = lens[phase];
    assign nx      = next_phase(phase, ena);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (phase == PH_IDLE) begin
                if (start) begin
                    cnt   <= '0;
                    phase <= nx;
                    done  <= (nx == PH_IDLE);
                end
            end else if (cnt == cur_len) begin
                cnt   <= '0;
                phase <= nx;
                done  <= (nx == PH_IDLE);
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_PHASE_FORWARD: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && $past(phase) != PH_IDLE && phase != $past(phase))
            |-> (phase > $past(phase))); // R2

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |-> (cnt <= cur_len)); // R2

endmodule

// File: rtl/spi_phase_seq_buf.sv
module spi_phase_seq_buf #(
    parameter int WORDS  = 16,
    parameter int WORD_W = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            host_we,
    input  logic [$clog2(WORDS)-1:0]        host_addr,
    input  logic [WORD_W-1:0]               host_wdata,
    output logic [WORD_W-1:0]               host_rdata,
    input  logic [$clog2(WORDS*WORD_W)-1:0] tx_idx,
    output logic                            tx_bit,
    input  logic                            rx_we,
    input  logic [$clog2(WORDS*WORD_W)-1:0] rx_idx,
    input  logic                            rx_bit
);
    localparam int BW = $clog2(WORD_W);
    localparam int IW = $clog2(WORDS*WORD_W);

    logic [WORD_W-1:0] mem [WORDS];

    // WORD_W is a power of two, so 'WORD_W-1 - k' is the bitwise complement of k.
    assign host_rdata = mem[host_addr];
    assign tx_bit     = mem[tx_idx[IW-1:BW]][~tx_idx[BW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '0;
        end else begin
            if (host_we) mem[host_addr] <= host_wdata;
            if (rx_we)   mem[rx_idx[IW-1:BW]][~rx_idx[BW-1:0]] <= rx_bit;
        end
    end

    AST_NO_PORT_CLASH: assert property (@(posedge clk) disable iff (rst)
        !(host_we && rx_we)); // R12

endmodule

// File: rtl/spi_phase_seq.sv
module spi_phase_seq
    import spi_phase_seq_pkg::*;
#(
    parameter int WORDS   = 16,
    parameter int WORD_W  = 32,
    parameter int LEN_W   = 24,
    parameter int CMD_W   = 16,
    parameter int ADDR_HW = 32,
    parameter int DUMMY_W = 8,
    parameter int TIME_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic                     en_cmd,
    input  logic                     en_addr,
    input  logic                     en_dummy,
    input  logic                     en_wr,
    input  logic                     en_rd,
    input  logic                     full_duplex,
    input  logic                     dummy_idle,
    input  logic                     setup_en,
    input  logic                     hold_en,
    input  logic                     wr_upper,
    input  logic                     rd_upper,
    input  logic [TIME_W-1:0]        setup_len,
    input  logic [TIME_W-1:0]        hold_len,
    input  logic [$clog2(CMD_W)-1:0] cmd_len,
    input  logic [CMD_W-1:0]         cmd_val,
    input  logic [$clog2(2*ADDR_HW)-1:0] addr_len,
    input  logic [ADDR_HW-1:0]       addr_lo,
    input  logic [ADDR_HW-1:0]       addr_hi,
    input  logic [DUMMY_W-1:0]       dummy_len,
    input  logic [LEN_W-1:0]         wr_len,
    input  logic [LEN_W-1:0]         rd_len,
    input  logic                     buf_we,
    input  logic [$clog2(WORDS)-1:0] buf_addr,
    input  logic [WORD_W-1:0]        buf_wdata,
    output logic [WORD_W-1:0]        buf_rdata,
    output logic                     busy,
    output logic                     done,
    output logic [2:0]               phase,
    output logic                     cs_n,
    output logic                     sck_en,
    output logic                     mosi,
    input  logic                     miso
);
    localparam int CLW = $clog2(CMD_W);
    localparam int ALW = $clog2(2*ADDR_HW);
    localparam int IW  = $clog2(WORDS*WORD_W);

    phase_e                ph;
    phase_en_t             ena;
    logic [7:0][LEN_W-1:0] lens;
    logic [LEN_W-1:0]      cnt;
    logic [IW-1:0]         tx_idx, rx_idx;
    logic                  tx_bit, rx_we;
    logic [CLW-1:0]        cmd_sel;
    logic [ALW-1:0]        addr_sel;
    logic [2*ADDR_HW-1:0]  addr_all;

    assign ena = '{lead: setup_en, cmd: en_cmd, addr: en_addr, dummy: en_dummy,
                   wr: en_wr, rd: en_rd, fdx: full_duplex, tail: hold_en};

    always_comb begin
        lens           = '0;
        lens[PH_LEAD]  = LEN_W'(setup_len);
        lens[PH_CMD]   = LEN_W'(cmd_len);
        lens[PH_ADDR]  = LEN_W'(addr_len);
        lens[PH_DUMMY] = LEN_W'(dummy_len);
        lens[PH_WR]    = wr_len;
        lens[PH_RD]    = rd_len;
        lens[PH_TAIL]  = LEN_W'(hold_len);
    end

    spi_phase_seq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ena   (ena),
        .lens  (lens),
        .phase (ph),
        .cnt   (cnt),
        .done  (done)
    );

    assign tx_idx = wr_upper ? {1'b1, cnt[IW-2:0]} : cnt[IW-1:0];
    assign rx_idx = rd_upper ? {1'b1, cnt[IW-2:0]} : cnt[IW-1:0];
    assign rx_we  = (ph == PH_RD) || (ph == PH_WR && full_duplex);

    spi_phase_seq_buf #(.WORDS(WORDS), .WORD_W(WORD_W)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .host_we    (buf_we && ph == PH_IDLE),
        .host_addr  (buf_addr),
        .host_wdata (buf_wdata),
        .host_rdata (buf_rdata),
        .tx_idx     (tx_idx),
        .tx_bit     (tx_bit),
        .rx_we      (rx_we),
        .rx_idx     (rx_idx),
        .rx_bit     (miso)
    );

    assign addr_all = {addr_hi, addr_lo};
    assign cmd_sel  = cmd_len - cnt[CLW-1:0];
    assign addr_sel = addr_len - cnt[ALW-1:0];

    always_comb begin
        unique case (ph)
            PH_CMD:  mosi = cmd_val[cmd_sel];
            PH_ADDR: mosi = addr_all[addr_sel];
            PH_WR:   mosi = tx_bit;
            default: mosi = 1'b0;
        endcase
    end

    assign busy   = (ph != PH_IDLE);
    assign cs_n   = ~busy;
    assign phase  = ph;
    assign sck_en = shifts_bits(ph) || (ph == PH_DUMMY && !dummy_idle);

    AST_CS_FROM_START: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> $past(start)); // R11

    AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> done); // R11

    AST_DUMMY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd4 && dummy_idle) |-> !sck_en); // R5

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!sck_en && !mosi)); // R1

endmodule

// File: tb/spi_phase_seq_test.sv
module spi_phase_seq_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [2:0] ph;
        logic       sck;
        logic       mo;
        logic       smp;
        logic [8:0] idx;
    } exp_t;

    logic clk = 0, rst = 1, start = 0;
    logic en_cmd = 0, en_addr = 0, en_dummy = 0, en_wr = 0, en_rd = 0;
    logic full_duplex = 0, dummy_idle = 0, setup_en = 0, hold_en = 0;
    logic wr_upper = 0, rd_upper = 0;
    logic [3:0]  setup_len = 0, hold_len = 0, cmd_len = 0;
    logic [15:0] cmd_val = 0;
    logic [5:0]  addr_len = 0;
    logic [31:0] addr_lo = 0, addr_hi = 0;
    logic [7:0]  dummy_len = 0;
    logic [23:0] wr_len = 0, rd_len = 0;
    logic        buf_we = 0;
    logic [3:0]  buf_addr = 0;
    logic [31:0] buf_wdata = 0;
    logic [31:0] buf_rdata;
    logic        busy, done, cs_n, sck_en, mosi, miso = 0;
    logic [2:0]  phase;

    int nchk = 0, nfail = 0;
    logic [31:0] model [16];
    exp_t        q [$];
    logic [31:0] slave_sr;

    spi_phase_seq uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 200000);
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk + 1, nfail + 1);
        $finish;
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        nchk++;
        if (ok !== 1'b1) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic string ph_tag(input logic [2:0] p);
        case (p)
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [8:0] map_idx(input int i, input logic up);
        logic [8:0] v;
        v = 9'(i);
        if (up) v[8] = 1'b1;
        return v;
    endfunction

    task automatic host_write(input int w, input logic [31:0] d);
        @(negedge clk);
        buf_we = 1; buf_addr = 4'(w); buf_wdata = d;
        @(negedge clk);
        buf_we = 0;
        model[w] = d;
    endtask

    // Driver: push the expected cycle stream for the present configuration.
    task automatic build_expect();
        logic [63:0] a;
        logic [8:0]  ix;
        exp_t        e;
        a = {addr_hi, addr_lo};
        q.delete();
        if (setup_en) for (int i = 0; i <= int'(setup_len); i++) q.push_back('{3'd1, 1'b0, 1'b0, 1'b0, 9'd0});
        if (en_cmd)   for (int i = 0; i <= int'(cmd_len); i++)   q.push_back('{3'd2, 1'b1, cmd_val[int'(cmd_len) - i], 1'b0, 9'd0});
        if (en_addr)  for (int i = 0; i <= int'(addr_len); i++)  q.push_back('{3'd3, 1'b1, a[int'(addr_len) - i], 1'b0, 9'd0});
        if (en_dummy) for (int i = 0; i <= int'(dummy_len); i++) q.push_back('{3'd4, !dummy_idle, 1'b0, 1'b0, 9'd0});
        if (en_wr) for (int i = 0; i <= int'(wr_len); i++) begin
            ix = map_idx(i, wr_upper);
            e  = '{3'd5, 1'b1, model[ix[8:5]][31 - int'(ix[4:0])], full_duplex, map_idx(i, rd_upper)};
            q.push_back(e);
        end
        if (en_rd && !full_duplex) for (int i = 0; i <= int'(rd_len); i++) q.push_back('{3'd6, 1'b1, 1'b0, 1'b1, map_idx(i, rd_upper)});
        if (hold_en) for (int i = 0; i <= int'(hold_len); i++) q.push_back('{3'd7, 1'b0, 1'b0, 1'b0, 9'd0});
    endtask

    // Monitor: compare one cycle of outputs with the head of the queue.
    task automatic monitor_step(inout logic was_busy, inout logic ended);
        exp_t e;
        miso = 1'b0;
        if (busy) begin
            chk(cs_n == 1'b0, "R11 cs_n while busy", 32'(cs_n), 32'd0);
            if (q.size() == 0) begin
                chk(1'b0, "R2 extra busy cycle", 32'(phase), 32'd0);
            end else begin
                e = q.pop_front();
                chk(phase == e.ph, "R2 phase order", 32'(phase), 32'(e.ph));
                chk(sck_en == e.sck, ph_tag(e.ph), 32'(sck_en), 32'(e.sck));
                chk(mosi == e.mo, ph_tag(e.ph), 32'(mosi), 32'(e.mo));
                if (e.smp) begin
                    miso = slave_sr[31];
                    slave_sr = {slave_sr[30:0], slave_sr[31] ^ slave_sr[21]};
                    model[e.idx[8:5]][31 - int'(e.idx[4:0])] = miso;
                end
            end
        end
        if (was_busy && !busy) begin
            chk(done == 1'b1, "R11 done pulse", 32'(done), 32'd1);
            chk(q.size() == 0, "R2 transaction ended early", 32'(q.size()), 32'd0);
            ended = 1'b1;
        end
        was_busy = busy;
    endtask

    task automatic run(input string dtag, input logic poke);
        logic was_busy, ended;
        int   cyc;
        build_expect();
        slave_sr = 32'hB4E1_6C3D ^ {8'd0, wr_len};
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        was_busy = 1'b1; ended = 1'b0; cyc = 0;
        while (!ended && cyc < 20000) begin
            monitor_step(was_busy, ended);
            if (poke && cyc == 3) begin
                start = 1; buf_we = 1; buf_addr = 4'd15; buf_wdata = 32'hFFFF_FFFF;
            end else begin
                start = 0; buf_we = 0;
            end
            cyc++;
            if (!ended) @(negedge clk);
        end
        start = 0; buf_we = 0;
        if (!ended) chk(1'b0, "R11 transaction never ended", 32'(cyc), 32'd0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!busy && cs_n && !sck_en && !mosi,
                poke ? "R12 restart while busy" : "R1 idle lines",
                {28'd0, busy, cs_n, sck_en, mosi}, 32'h4);
        end
        for (int w = 0; w < 16; w++) begin
            buf_addr = 4'(w);
            #1;
            chk(buf_rdata == model[w], dtag, buf_rdata, model[w]);
        end
    endtask

    task automatic clear_cfg();
        en_cmd = 0; en_addr = 0; en_dummy = 0; en_wr = 0; en_rd = 0;
        full_duplex = 0; dummy_idle = 0; setup_en = 0; hold_en = 0;
        wr_upper = 0; rd_upper = 0;
    endtask

    initial begin
        for (int w = 0; w < 16; w++) model[w] = 32'd0;
        repeat (3) @(negedge clk);
        chk(cs_n && !busy && !sck_en && !mosi && phase == 3'd0 && !done,
            "R1 reset state", {25'd0, phase, cs_n, busy, sck_en, mosi}, 32'h8);
        rst = 0;
        for (int w = 0; w < 16; w++) host_write(w, 32'h1357_9BDF ^ (32'(w) * 32'h0F1E_2D3C));

        // Command, address and write data, half duplex (R3, R4, R6).
        clear_cfg();
        en_cmd = 1; cmd_len = 4'd11; cmd_val = 16'h3C5A;
        en_addr = 1; addr_len = 6'd23; addr_lo = 32'h0012_3456;
        en_wr = 1; wr_len = 24'd39;
        run("R6 buffer after write", 1'b0);

        // Lead-in, gated dummy, read data and tail (R5, R7, R10).
        clear_cfg();
        setup_en = 1; setup_len = 4'd2; hold_en = 1; hold_len = 4'd3;
        en_cmd = 1; cmd_len = 4'd7; cmd_val = 16'h009B;
        en_dummy = 1; dummy_idle = 1; dummy_len = 8'd5;
        en_rd = 1; rd_len = 24'd19;
        run("R7 received data", 1'b0);

        // Full duplex from the upper half, read phase enabled but skipped (R8, R9).
        clear_cfg();
        en_wr = 1; wr_len = 24'd63; wr_upper = 1;
        en_rd = 1; rd_len = 24'd9; full_duplex = 1;
        run("R8 R9 full duplex data", 1'b0);

        // Long address, running dummy, upper read half, poked while busy (R4, R5, R9, R12).
        clear_cfg();
        en_addr = 1; addr_len = 6'd39; addr_hi = 32'h0000_00AB; addr_lo = 32'hC0DE_F00D;
        en_dummy = 1; dummy_len = 8'd2;
        en_rd = 1; rd_len = 24'd44; rd_upper = 1;
        run("R9 R12 upper read and blocked write", 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule